// File: doc/BRIEF.md
# Activity-Adaptive Threshold LIF Layer

This block is one layer of discrete-time leaky integrate-and-fire neurons. All neurons in the layer share a single firing threshold. Each accepted timestep brings one pre-summed signed input current per neuron. Every neuron leaks its membrane potential by an unsigned decay factor, adds its current and compares the result with the shared threshold. A neuron that fires has the threshold subtracted from its potential. The layer then emits the resulting spike vector.

In the same cycle, the block counts how many neurons fired and compares that count with a programmed target count. It then moves the shared threshold for the next timestep. The threshold rises when the layer fires less than the target and falls when it fires more. The threshold is always bounded by a programmable floor and ceiling.

Timesteps arrive on a valid/ready stream and results leave on another. The output holds one timestep. The input is ready whenever that output slot is empty or is being drained in the same cycle. Holding `out_ready` low therefore stalls the layer with no state change and no lost timestep. Configuration pins are plain levels and are expected to stay steady while timesteps flow. The neuron count N must be a power of two, because the division by N is a shift.

Top module: `adaptive_lif_layer`

## Requirements
- R1: On each accepted timestep, neuron i (current lane `in_current[i*16 +: 16]`, spike bit `out_spikes[i]`) forms u = floor(v*beta/256) + current. Here v is its signed 16-bit potential and beta is the unsigned 8-bit `cfg_beta`.
- R2: A neuron fires when u is greater than or equal to the threshold in force for that timestep. A firing neuron keeps u minus the threshold as its new potential. A silent neuron keeps u.
- R3: u saturates to the range -32768..32767 and never wraps.
- R4: Let c be the number of neurons that fired. The candidate next threshold is base + floor(base*gain*(target - c) / (16*N)). Here base is `cfg_base`, gain is `cfg_gain` (unsigned, 4 fraction bits) and target is `cfg_target` (a count out of N).
- R5: The threshold computed from timestep t takes effect at timestep t+1. It appears on `thr_o` together with that timestep's spikes.
- R6: The candidate is first limited to at most `cfg_thr_max` and then raised to at least `cfg_thr_min`. A floor of 0 acts as 1, so the threshold is never 0.
- R7: While `rst_n` is low at a clock edge, all potentials clear to 0 and `out_valid` clears. The threshold loads `cfg_base` after the limits of R6 are applied.
- R8: A timestep is accepted only on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the spikes, the threshold and all potentials hold.
- R9: With the limits wide enough, a timestep whose spike count is below the target yields a threshold above base. A count above the target yields one below base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 15 | Base threshold |
| cfg_target | input | 4 | Target spike count per timestep (0..N) |
| cfg_gain | input | 8 | Adaptation gain, unsigned, 4 fraction bits |
| cfg_beta | input | 8 | Leak multiplier, unsigned, 8 fraction bits |
| cfg_thr_min | input | 15 | Threshold floor (0 acts as 1) |
| cfg_thr_max | input | 15 | Threshold ceiling |
| in_valid | input | 1 | Input timestep present |
| in_ready | output | 1 | Layer can take a timestep |
| in_current | input | 128 | Signed 16-bit current per neuron, lane i at bits i*16 and up |
| out_valid | output | 1 | Spike vector present |
| out_ready | input | 1 | Consumer takes the spike vector |
| out_spikes | output | 8 | Spike vector of the last accepted timestep |
| thr_o | output | 15 | Threshold for the next timestep |

## Verification
Spikes and the adapted threshold of an accepted timestep both appear one clock edge after acceptance. The bench drives each timestep on a falling edge and lets one rising edge pass. It samples `out_spikes`, `thr_o` and `out_valid` on the following falling edge and compares them with a reference model that it steps once per accepted timestep. During a stall, the outputs are sampled on every falling edge until `out_ready` returns. The timestep that was waiting is then modelled at the edge where it is actually taken.

// File: rtl/lif_pkg.sv
package lif_pkg;
  // Leak multiplier: unsigned, all bits are fraction bits
  localparam int unsigned BETA_W    = 8;
  localparam int unsigned BETA_FRAC = 8;

  // Which limit, if any, shaped the next threshold
  typedef enum logic [1:0] {
    LIM_NONE = 2'd0,
    LIM_LOW  = 2'd1,
    LIM_HIGH = 2'd2
  } lim_e;
endpackage

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [BETA_W-1:0]    beta,
  input  logic signed [PW-1:0] cur,
  input  logic [PW-2:0]        thr,
  output logic                 spike
);
  localparam int unsigned MW = PW + BETA_W + 1;

  localparam logic signed [PW:0] SAT_HI = {2'b00, {(PW-1){1'b1}}};
  localparam logic signed [PW:0] SAT_LO = {2'b11, {(PW-1){1'b0}}};

  logic signed [PW-1:0] v_q;
  logic signed [PW-1:0] v_next;
  logic signed [MW-1:0] dprod;
  logic signed [PW-1:0] leaked;
  logic signed [PW:0]   sum;
  logic signed [PW-1:0] u;
  logic signed [PW-1:0] thr_s;

  always_comb begin
    thr_s  = $signed({1'b0, thr});
    dprod  = MW'(v_q) * MW'($signed({1'b0, beta}));
    leaked = PW'(dprod >>> BETA_FRAC);
    sum    = (PW+1)'(leaked) + (PW+1)'(cur);
    if (sum > SAT_HI)      u = SAT_HI[PW-1:0];
    else if (sum < SAT_LO) u = SAT_LO[PW-1:0];
    else                   u = sum[PW-1:0];
    spike  = (u >= thr_s);
    v_next = spike ? (u - thr_s) : u;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    v_q <= '0;
    else if (fire) v_q <= v_next;
  end

  // R8
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(v_q));

  // R2
  v_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && spike && thr != '0) |=> (v_q < $past(u)));
endmodule

// File: rtl/spike_counter.sv
module spike_counter #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/thr_adapter.sv
module thr_adapter
  import lif_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter int unsigned TW        = 15,
  parameter int unsigned GW        = 8,
  parameter int unsigned GAIN_FRAC = 4,
  parameter int unsigned CW        = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          update,
  input  logic [CW-1:0] cnt,
  input  logic [TW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_target,
  input  logic [GW-1:0] cfg_gain,
  input  logic [TW-1:0] cfg_thr_min,
  input  logic [TW-1:0] cfg_thr_max,
  output logic [TW-1:0] thr_q
);
  localparam int unsigned DW    = CW + 1;
  localparam int unsigned PRW   = TW + GW + DW + 2;
  localparam int unsigned SHIFT = GAIN_FRAC + $clog2(N);

  logic signed [DW-1:0]  diff;
  logic signed [PRW-1:0] prod;
  logic signed [PRW-1:0] raw;
  logic [TW-1:0]         eff_min;
  logic [TW-1:0]         thr_next;
  logic [TW-1:0]         base_lim;
  lim_e                  lim_sel;

  function automatic logic [TW-1:0] apply_limits(
    input logic signed [PRW-1:0] val,
    input logic [TW-1:0]         lo,
    input logic [TW-1:0]         hi
  );
    logic signed [PRW-1:0] t;
    t = val;
    if (t > PRW'($signed({1'b0, hi}))) t = PRW'($signed({1'b0, hi}));
    if (t < PRW'($signed({1'b0, lo}))) t = PRW'($signed({1'b0, lo}));
    return t[TW-1:0];
  endfunction

  always_comb begin
    eff_min = (cfg_thr_min == '0) ? TW'(1) : cfg_thr_min;
    diff    = $signed({1'b0, cfg_target}) - $signed({1'b0, cnt});
    prod    = PRW'($signed({1'b0, cfg_base})) * PRW'($signed({1'b0, cfg_gain}))
            * PRW'(diff);
    raw     = PRW'($signed({1'b0, cfg_base})) + (prod >>> SHIFT);
    if (raw < PRW'($signed({1'b0, eff_min})) ||
        PRW'($signed({1'b0, cfg_thr_max})) < PRW'($signed({1'b0, eff_min})))
      lim_sel = LIM_LOW;
    else if (raw > PRW'($signed({1'b0, cfg_thr_max})))
      lim_sel = LIM_HIGH;
    else
      lim_sel = LIM_NONE;
    case (lim_sel)
      LIM_LOW:  thr_next = eff_min;
      LIM_HIGH: thr_next = cfg_thr_max;
      default:  thr_next = raw[TW-1:0];
    endcase
    base_lim = apply_limits(PRW'($signed({1'b0, cfg_base})), eff_min, cfg_thr_max);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= base_lim;
    else if (update) thr_q <= thr_next;
  end

  // R6
  thr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q != '0);

  // R8
  thr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(thr_q));

  // R9
  thr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update && cnt < cfg_target && cfg_gain != '0 && cfg_base >= TW'(16 * N)
     && cfg_thr_max == {TW{1'b1}} && eff_min <= cfg_base)
    |=> thr_q > $past(cfg_base));
endmodule

// File: rtl/adaptive_lif_layer.sv
module adaptive_lif_layer
  import lif_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter int unsigned PW        = 16,
  parameter int unsigned GW        = 8,
  parameter int unsigned GAIN_FRAC = 4,
  localparam int unsigned TW       = PW - 1,
  localparam int unsigned CW       = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_base,
  input  logic [CW-1:0]     cfg_target,
  input  logic [GW-1:0]     cfg_gain,
  input  logic [BETA_W-1:0] cfg_beta,
  input  logic [TW-1:0]     cfg_thr_min,
  input  logic [TW-1:0]     cfg_thr_max,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N*PW-1:0]   in_current,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [N-1:0]      out_spikes,
  output logic [TW-1:0]     thr_o
);
  logic          fire;
  logic [N-1:0]  spk_next;
  logic [CW-1:0] cnt;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar g = 0; g < N; g++) begin : g_neuron
    lif_neuron #(.PW(PW)) u_neuron (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .beta  (cfg_beta),
      .cur   ($signed(in_current[g*PW +: PW])),
      .thr   (thr_o),
      .spike (spk_next[g])
    );
  end

  spike_counter #(.N(N), .CW(CW)) u_count (
    .vec (spk_next),
    .cnt (cnt)
  );

  thr_adapter #(
    .N(N), .TW(TW), .GW(GW), .GAIN_FRAC(GAIN_FRAC), .CW(CW)
  ) u_adapt (
    .clk         (clk),
    .rst_n       (rst_n),
    .update      (fire),
    .cnt         (cnt),
    .cfg_base    (cfg_base),
    .cfg_target  (cfg_target),
    .cfg_gain    (cfg_gain),
    .cfg_thr_min (cfg_thr_min),
    .cfg_thr_max (cfg_thr_max),
    .thr_q       (thr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_spikes <= '0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_spikes <= spk_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_spikes) && $stable(thr_o)));

  // R4
  cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cnt == CW'($countones(spk_next))));

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
endmodule

// File: tb/adaptive_lif_layer_tb.sv
`timescale 1ns/1ps
module adaptive_lif_layer_tb_top;
  localparam int N  = 8;
  localparam int PW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [14:0]    cfg_base, cfg_thr_min, cfg_thr_max;
  logic [3:0]     cfg_target;
  logic [7:0]     cfg_gain, cfg_beta;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [127:0]   in_current = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [7:0]     out_spikes;
  logic [14:0]    thr_o;

  int n_chk = 0;
  int n_bad = 0;
  int v_m [N];
  int thr_m;
  logic [7:0] spk_m;

  always #2.5 clk = ~clk;

  adaptive_lif_layer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_target(cfg_target),
    .cfg_gain(cfg_gain), .cfg_beta(cfg_beta), .cfg_thr_min(cfg_thr_min),
    .cfg_thr_max(cfg_thr_max), .in_valid(in_valid), .in_ready(in_ready),
    .in_current(in_current), .out_valid(out_valid), .out_ready(out_ready),
    .out_spikes(out_spikes), .thr_o(thr_o)
  );

  // Stimulus table: one packed current vector per timestep, lane 0 in low bits
  localparam logic [127:0] STIM [12] = '{
    {8{16'd40}},
    {8{16'd40}},
    {8{16'd40}},
    {16'd300, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0},
    {8{16'd150}},
    {8{16'd0}},
    {4{16'd90, 16'hFFC0}},
    {8{16'd0}},
    {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10},
    {8{16'd120}},
    {8{16'hFF00}},
    {8{16'd200}}
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lim(input int raw);
    int mn;
    mn = (cfg_thr_min == 0) ? 1 : int'(cfg_thr_min);
    if (raw > int'(cfg_thr_max)) raw = int'(cfg_thr_max);
    if (raw < mn) raw = mn;
    return raw;
  endfunction

  function automatic int sat16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // Reference model of one accepted timestep (R1, R2, R3, R4, R6)
  task automatic model_step(input logic [127:0] cur);
    int b, c, u, cnt, base, gain, tgt;
    b = int'(cfg_beta);
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      c = int'($signed(cur[i*PW +: PW]));
      u = sat16(((v_m[i] * b) >>> 8) + c);
      spk_m[i] = (u >= thr_m);
      if (spk_m[i]) begin
        v_m[i] = u - thr_m;
        cnt++;
      end else begin
        v_m[i] = u;
      end
    end
    base = int'(cfg_base);
    gain = int'(cfg_gain);
    tgt  = int'(cfg_target);
    thr_m = lim(base + ((base * gain * (tgt - cnt)) >>> 7));
  endtask

  task automatic check_out(input string req);
    chk(req, int'(out_valid), 1, "out_valid");
    chk(req, int'(out_spikes), int'(spk_m), "spikes");
    chk(req, int'(thr_o), thr_m, "threshold");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) v_m[i] = 0;
    thr_m = lim(int'(cfg_base));
    spk_m = '0;
  endtask

  task automatic step(input logic [127:0] cur, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_current = cur;
    @(posedge clk);
    model_step(cur);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req);
  endtask

  task automatic set_cfg(input int base, input int tgt, input int gain, input int beta,
                         input int mn, input int mx);
    cfg_base = 15'(base); cfg_target = 4'(tgt); cfg_gain = 8'(gain);
    cfg_beta = 8'(beta); cfg_thr_min = 15'(mn); cfg_thr_max = 15'(mx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    set_cfg(100, 2, 16, 230, 10, 400);
    do_reset();
    @(negedge clk);
    // R7 reset state
    chk("R7", int'(out_valid), 0, "out_valid after reset");
    chk("R7", int'(in_ready), 1, "in_ready after reset");
    chk("R7", int'(thr_o), 100, "threshold after reset");

    // Table walk: R1 R2 R4 R5
    for (int k = 0; k < 12; k++) step(STIM[k], "R1/R2/R4/R5");

    // R9: count below target raises the threshold above base
    do_reset();
    step({8{16'd0}}, "R9");
    chk("R9", int'(thr_o > 15'd100), 1, "threshold above base");
    // R9: count above target lowers it below base
    step({8{16'd2000}}, "R9");
    chk("R9", int'(thr_o < 15'd100), 1, "threshold below base");

    // R6: floor of 0 acts as 1
    set_cfg(100, 0, 16, 230, 0, 400);
    do_reset();
    step({8{16'd200}}, "R6");
    chk("R6", int'(thr_o), 1, "floor clamp");
    step({8{16'd0}}, "R6");
    // R6: ceiling clamp
    set_cfg(100, 8, 16, 230, 10, 150);
    do_reset();
    step({8{16'd0}}, "R6");
    chk("R6", int'(thr_o), 150, "ceiling clamp");

    // R3: positive saturation keeps firing
    set_cfg(100, 2, 16, 255, 10, 400);
    do_reset();
    step({8{16'h7FFF}}, "R3");
    step({8{16'h7FFF}}, "R3");
    chk("R3", int'(out_spikes), 255, "all fire after positive saturation");
    // R3: negative saturation must not wrap to a positive value
    do_reset();
    step({8{16'h8000}}, "R3");
    step({8{16'h8000}}, "R3");
    chk("R3", int'(out_spikes), 0, "silent after negative saturation");
    step({8{16'd100}}, "R3");

    // R8: back-pressure holds outputs and state
    set_cfg(100, 2, 16, 230, 10, 400);
    do_reset();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_current = {8{16'd150}};
    @(posedge clk);
    model_step({8{16'd150}});
    @(negedge clk);
    in_current = {8{16'd500}};
    for (int k = 0; k < 3; k++) begin
      chk("R8", int'(in_ready), 0, "in_ready during stall");
      check_out("R8");
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    model_step({8{16'd500}});
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R8");
    @(negedge clk);
    chk("R8", int'(out_valid), 0, "drained");
    // R7: mid-run reset clears potentials
    step({8{16'd90}}, "R7");
    do_reset();
    @(negedge clk);
    chk("R7", int'(thr_o), 100, "threshold reloaded");
    step({8{16'd0}}, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule